// File: doc/BRIEF.md
# Watchdog and Pin-Triggered Reset Generator

This block raises a system reset request from three causes: a small watchdog counter that software has to clear at regular intervals, a selectable OR of the port input pins, and an external reset input. The watchdog counter steps forward on each slow tick, which is a single-cycle enable in the fast clock domain. It raises the request when it reaches its all-ones state. Software can clear the counter or inhibit it through a one-cycle write strobe that carries two data bits. The current count can be read back at all times.

Each pin has a 2-bit option field. The field picks what the pin contributes to the request: a constant low, the pin level, the inverted pin level, or a constant high. The contributions of all pins are ORed together.

The final reset output is registered. Whenever it is high, it clears the counter and the inhibit bit, so every reset leaves the watchdog enabled and counting from zero.

Top module: `wdog_pin_rstgen`

## Requirements
- R1: With no reset, no inhibit and no clear, each cycle with `tick` high moves `wd_count` forward one step, in the order 0, 1, 2, 3 (the 2-bit default). Once the count is 3 it holds at 3.
- R2: In the cycle after `wd_count` holds 3, `sys_rst` is high.
- R3: A write (`wr_en` high) with `wr_clear`=1 makes `wd_count` 0 on the next cycle, and counting then continues from 0. A write with `wr_clear`=0 and `wr_inhibit`=0 leaves the count unchanged.
- R4: A write latches `wr_inhibit` as the inhibit bit. While the inhibit bit is 1, `wd_count` is 0 from the following cycle onward, and ticks cause neither counting nor a reset.
- R5: While `sys_rst` is high, the counter returns to 0 and the inhibit bit clears, both on the next cycle.
- R6: Pin i uses option field `pin_opt[2i+1:2i]`. Value 00 contributes 0, 01 contributes `pins[i]`, 10 contributes `~pins[i]`, and 11 contributes 1.
- R7: `sys_rst` on the next cycle is the OR of all pin contributions, the watchdog request and `ext_rst`. A pin whose field is 11 keeps the reset high for as long as the field stays 11. A pin whose field is 00 has no effect.
- R8: `ext_rst` high makes `sys_rst` high on the next cycle.
- R9: While `rst_n` is low, `sys_rst` is high, `wd_count` is 0 and the inhibit bit is clear.
- R10: `wd_count` always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Slow tick, one-cycle enable |
| wr_en | input | 1 | Control register write strobe |
| wr_clear | input | 1 | Write data: 1 clears the watchdog |
| wr_inhibit | input | 1 | Write data: new value of the inhibit bit |
| pins | input | NUM_PINS | Port input pins |
| pin_opt | input | 2*NUM_PINS | Per-pin 2-bit contribution select |
| ext_rst | input | 1 | External reset request |
| wd_count | output | CNT_W | Watchdog counter status |
| sys_rst | output | 1 | Registered system reset |

## Verification
The pin OR is driven with all four option values on one pin, each at both pin levels, while a second pin follows its own level. This separates the low, follow, invert and force selections from one another and shows that the OR lets either pin cause the reset. The watchdog is run through four sequences: a full count with no clear, which must end in a reset; regular clears, which must keep the reset low; a write with the clear bit at 0, which must leave the count alone; and inhibit with ticks, which must hold the count at zero. An external reset taken while the watchdog is inhibited shows that any reset source re-enables the watchdog. A forced-high pin shows that the reset stays on.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   typedef enum logic [1:0] {
      SEL_LOW  = 2'b00,
      SEL_PIN  = 2'b01,
      SEL_INV  = 2'b10,
      SEL_HIGH = 2'b11
   } pin_sel_e;
endpackage

// File: rtl/rstgen_pin_or.sv
module rstgen_pin_or #(
   parameter int NUM_PINS = 4
) (
   input  logic [NUM_PINS-1:0]   pins_i,
   input  logic [2*NUM_PINS-1:0] opt_i,
   output logic                  req_o
);
   import rstgen_pkg::*;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("rstgen_pin_or: NUM_PINS must be at least 1");
   end

   logic [NUM_PINS-1:0] term;

   // One 4-way selector per pin
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_sel_e sel;
      assign sel = pin_sel_e'(opt_i[2*i +: 2]);
      always_comb begin
         case (sel)
            SEL_LOW:  term[i] = 1'b0;
            SEL_PIN:  term[i] = pins_i[i];
            SEL_INV:  term[i] = ~pins_i[i];
            default:  term[i] = 1'b1;
         endcase
      end
   end

   assign req_o = |term;
endmodule

// File: rtl/rstgen_wdog.sv
module rstgen_wdog #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_rst_i,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic             wr_clear_i,
   input  logic             wr_inhibit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             req_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("rstgen_wdog: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q;
   logic             inhibit_q;
   logic             clear_wr;

   assign clear_wr = wr_en_i & wr_clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inhibit_q <= 1'b0;
      end else if (sys_rst_i) begin
         inhibit_q <= 1'b0;
      end else if (wr_en_i) begin
         inhibit_q <= wr_inhibit_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (sys_rst_i || inhibit_q || clear_wr) begin
         count_q <= '0;
      end else if (tick_i && count_q != CNT_MAX) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;
   assign req_o   = (count_q == CNT_MAX);

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !inhibit_q && !sys_rst_i && !clear_wr && count_q != CNT_MAX)
      |=> (count_q == $past(count_q) + 1'b1));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_wr |=> (count_q == '0));

   assert_inhibit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_q |=> (count_q == '0));

   assert_rst_reenable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_i |=> (count_q == '0 && !inhibit_q));
endmodule

// File: rtl/wdog_pin_rstgen.sv
module wdog_pin_rstgen #(
   parameter int CNT_W    = 2,
   parameter int NUM_PINS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  wr_en,
   input  logic                  wr_clear,
   input  logic                  wr_inhibit,
   input  logic [NUM_PINS-1:0]   pins,
   input  logic [2*NUM_PINS-1:0] pin_opt,
   input  logic                  ext_rst,
   output logic [CNT_W-1:0]      wd_count,
   output logic                  sys_rst
);
   logic wd_req;
   logic pin_req;
   logic sys_rst_q;

   rstgen_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .sys_rst_i    (sys_rst_q),
      .tick_i       (tick),
      .wr_en_i      (wr_en),
      .wr_clear_i   (wr_clear),
      .wr_inhibit_i (wr_inhibit),
      .count_o      (wd_count),
      .req_o        (wd_req)
   );

   rstgen_pin_or #(.NUM_PINS(NUM_PINS)) u_pin_or (
      .pins_i (pins),
      .opt_i  (pin_opt),
      .req_o  (pin_req)
   );

   // Registered OR of all reset sources
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_rst_q <= 1'b1;
      end else begin
         sys_rst_q <= wd_req | pin_req | ext_rst;
      end
   end

   assign sys_rst = sys_rst_q;

   assert_wdog_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_count == {CNT_W{1'b1}}) |=> sys_rst);

   assert_pin_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_req |=> sys_rst);

   assert_ext_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> sys_rst);
endmodule

// File: tb/wdog_pin_rstgen_bench.sv
module wdog_pin_rstgen_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_clear = 1'b0;
   logic       wr_inhibit = 1'b0;
   logic [3:0] pins = '0;
   logic [7:0] pin_opt = '0;
   logic       ext_rst = 1'b0;
   logic [1:0] wd_count;
   logic       sys_rst;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_pin_rstgen u_wdog_pin_rstgen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_clear(wr_clear), .wr_inhibit(wr_inhibit), .pins(pins),
      .pin_opt(pin_opt), .ext_rst(ext_rst), .wd_count(wd_count),
      .sys_rst(sys_rst)
   );

   // {pin0 option, pin0 level, pin1 level, expected sys_rst}; pin1 option = follow
   localparam logic [4:0] PIN_VEC [16] = '{
      5'b00_0_0_0, 5'b00_0_1_1, 5'b00_1_0_0, 5'b00_1_1_1,
      5'b01_0_0_0, 5'b01_0_1_1, 5'b01_1_0_1, 5'b01_1_1_1,
      5'b10_0_0_1, 5'b10_0_1_1, 5'b10_1_0_0, 5'b10_1_1_1,
      5'b11_0_0_1, 5'b11_0_1_1, 5'b11_1_0_1, 5'b11_1_1_1
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One cycle with tick high; returns at the negedge after the edge
   task automatic tick_once();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic wr(input logic clr, input logic inh);
      @(negedge clk) begin wr_en = 1'b1; wr_clear = clr; wr_inhibit = inh; end
      @(negedge clk) begin wr_en = 1'b0; wr_clear = 1'b0; wr_inhibit = 1'b0; end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      idle(3);
      chk("R9 sys_rst in reset", sys_rst, 1);
      chk("R9 count in reset", wd_count, 0);
      rst_n = 1'b1;
      idle(2);
      chk("R9 sys_rst after release", sys_rst, 0);

      // Pin vector table: R6 / R7
      pin_opt = 8'b0000_0100;
      foreach (PIN_VEC[k]) begin
         @(negedge clk) begin
            pin_opt[1:0] = PIN_VEC[k][4:3];
            pins[0]      = PIN_VEC[k][2];
            pins[1]      = PIN_VEC[k][1];
         end
         @(negedge clk);
         chk($sformatf("R6 R7 pin vector %0d", k), sys_rst, PIN_VEC[k][0]);
      end
      @(negedge clk) begin pin_opt = '0; pins = '0; end
      idle(3);
      chk("R7 idle after pin table", sys_rst, 0);

      // R1 / R10: count sequence, then R2 / R5 watchdog firing
      tick_once(); chk("R1 R10 count step 1", wd_count, 1);
      tick_once(); chk("R1 count step 2", wd_count, 2);
      tick_once(); chk("R1 count step 3", wd_count, 3);
      chk("R2 no reset yet", sys_rst, 0);
      idle(1);
      chk("R2 watchdog reset", sys_rst, 1);
      idle(1);
      chk("R5 count cleared by reset", wd_count, 0);
      idle(1);
      chk("R2 reset pulse ends", sys_rst, 0);

      // R3: clear and write of zero
      tick_once(); tick_once();
      chk("R3 count before clear", wd_count, 2);
      wr(1'b1, 1'b0);
      chk("R3 count after clear", wd_count, 0);
      tick_once();
      chk("R3 counting resumes", wd_count, 1);
      wr(1'b0, 1'b0);
      chk("R3 zero write no effect", wd_count, 1);
      wr(1'b1, 1'b0);
      begin
         int seen = 0;
         for (int j = 0; j < 10; j++) begin
            tick_once(); if (sys_rst) seen++;
            tick_once(); if (sys_rst) seen++;
            wr(1'b1, 1'b0); if (sys_rst) seen++;
         end
         chk("R3 periodic clear prevents reset", seen, 0);
      end

      // R4: inhibit
      tick_once();
      wr(1'b0, 1'b1);
      idle(1);
      chk("R4 inhibited count zero", wd_count, 0);
      begin
         int seen = 0;
         for (int j = 0; j < 5; j++) begin
            tick_once(); if (sys_rst || wd_count != 0) seen++;
         end
         chk("R4 ticks ignored while inhibited", seen, 0);
      end
      wr(1'b0, 1'b0);
      tick_once(); tick_once(); tick_once();
      idle(1);
      chk("R4 R2 missed clear after inhibit off", sys_rst, 1);
      idle(3);

      // R8 / R5: external reset re-enables an inhibited watchdog
      wr(1'b0, 1'b1);
      idle(1);
      @(negedge clk) ext_rst = 1'b1;
      @(negedge clk) ext_rst = 1'b0;
      chk("R8 external reset", sys_rst, 1);
      idle(1);
      chk("R8 external reset ends", sys_rst, 0);
      tick_once();
      chk("R5 inhibit cleared by reset", wd_count, 1);

      // R7: forced-high pin holds reset
      @(negedge clk) pin_opt = 8'b0011_0000;
      begin
         int low = 0;
         for (int j = 0; j < 6; j++) begin
            tick_once(); if (!sys_rst || wd_count != 0) low++;
         end
         chk("R7 forced pin holds reset", low, 0);
      end
      @(negedge clk) pin_opt = '0;
      idle(3);
      chk("R7 release forced pin", sys_rst, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule